// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character into one serial frame on a single output line. A frame is a low start bit, then 5 to 9 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The character length, the parity mode and the number of stop bits are configuration inputs. They are captured together with the data word when a frame is accepted, so a frame in flight cannot be disturbed by changes on those inputs.

The line moves to its next bit only on a *step*. In asynchronous mode a step is a one-cycle `tick` pulse from an external bit-rate generator. In synchronous mode a step is an edge of the serial clock `sclk_in`: the rising edge when `clk_pol` is 0 and the falling edge when `clk_pol` is 1. The controller has seven states: `ST_IDLE`, `ST_ARM`, `ST_START`, `ST_DATA`, `ST_PAR`, `ST_STOP1` and `ST_STOP2`. Its transitions are:

- idle→arm on an accepted strobe.
- arm→start on a step, which drives the start bit.
- start→data on a step.
- data→data on each step until the last data bit.
- data→par, or data→stop1 when parity is off, on the step after the last data bit.
- par→stop1 on a step.
- stop1→stop2 on a step when two stop bits are set.
- stop1 or stop2 → idle on the final step. This is the finish step.
- stop1 or stop2 → start on the finish step when a new strobe arrives in that same cycle. This is the back-to-back path.

Top module: `sfr_tx`

## Requirements
- R1: A frame begins with exactly one start bit, driven low. The data bits follow it, least significant bit first.
- R2: `len_sel` values 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 data bits, and values 5 to 7 select 9 data bits. Only the selected number of bits is sent, and the last one is the highest selected bit.
- R3: `par_sel` encodes parity: 00 or 01 is none, 10 is even, 11 is odd. When parity is on, it is one bit placed between the last data bit and the first stop bit. Even parity is the XOR of the sent data bits, and odd parity is that XOR inverted.
- R4: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two. Every stop bit is high.
- R5: In asynchronous mode (`sync_en` = 0), `txd` changes only in the cycle after a `tick` pulse, and `sclk_in` has no effect.
- R6: In synchronous mode (`sync_en` = 1), `txd` changes only in the cycle after a rising edge of `sclk_in` when `clk_pol` = 0, or after a falling edge when `clk_pol` = 1. `tick` has no effect in this mode.
- R7: When idle, `txd` is high and `busy` is low. A strobe accepted in idle raises `busy` in the next cycle. The line stays high until the first step, which drives the start bit.
- R8: A strobe that arrives while busy, other than in the finish-step cycle, is ignored. Data and format are sampled only when a frame is accepted, so later changes to them do not alter the frame.
- R9: `done` is a one-cycle pulse that follows the step ending the last stop bit. Without a new strobe, `busy` drops in that same cycle and `txd` stays high.
- R10: A strobe in the finish-step cycle is accepted. The new start bit is driven at once with no idle time between the frames, and `busy` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request strobe |
| data_in | input | 9 | Character to send, LSB first |
| len_sel | input | 3 | Data length code |
| par_sel | input | 2 | Parity mode code |
| two_stop | input | 1 | 1 selects two stop bits |
| sync_en | input | 1 | 1 selects synchronous mode |
| clk_pol | input | 1 | Serial clock edge select in synchronous mode |
| sclk_in | input | 1 | Serial clock in synchronous mode |
| tick | input | 1 | Bit-rate pulse in asynchronous mode |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame finished pulse |

## Verification
The finish step of one frame can coincide with a new request. In that cycle the block must raise `done` and also accept the next character, moving straight to a low start bit.

The bench provokes this by holding `start` high across several frames, and it also sends pulsed strobes at other points in the frame, which must be ignored. A behavioural bit-queue model predicts, on every clock, whether the strobe is taken and what `txd`, `busy` and `done` must be. The bench also counts idle cycles between chained frames and expects none.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } sfr_state_e;

    // parity code: bit 1 enables, bit 0 selects odd
    localparam int PAR_EN_BIT  = 1;
    localparam int PAR_ODD_BIT = 0;

endpackage

// File: rtl/sfr_step_gen.sv
module sfr_step_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sync_en,
    input  logic clk_pol,
    input  logic sclk_in,
    output logic step
);
    logic sclk_q;
    logic sclk_rise;
    logic sclk_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_in;
        end
    end

    assign sclk_rise = sclk_in & ~sclk_q;
    assign sclk_fall = ~sclk_in & sclk_q;

    always_comb begin
        if (sync_en) begin
            step = clk_pol ? sclk_fall : sclk_rise;
        end else begin
            step = tick;
        end
    end
endmodule

// File: rtl/sfr_char_reg.sv
module sfr_char_reg #(
    parameter int DW      = 9,
    parameter int MIN_LEN = 5,
    parameter int LW      = 3,
    localparam int IW      = $clog2(DW),
    localparam int MAXCODE = DW - MIN_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] data_in,
    input  logic [LW-1:0] len_sel,
    input  logic [1:0]    par_sel,
    input  logic          two_stop,
    output logic [DW-1:0] data_q,
    output logic [IW-1:0] last_idx,
    output logic          par_on,
    output logic          par_bit,
    output logic          two_q
);
    import sfr_pkg::*;

    logic [IW-1:0] last_n;
    logic          par_n;

    // codes beyond the top length saturate to the widest character
    always_comb begin
        if (len_sel > LW'(MAXCODE)) begin
            last_n = IW'(DW - 1);
        end else begin
            last_n = IW'(MIN_LEN - 1) + IW'(len_sel);
        end
    end

    always_comb begin
        par_n = par_sel[PAR_ODD_BIT];
        for (int i = 0; i < DW; i++) begin
            if (IW'(i) <= last_n) begin
                par_n = par_n ^ data_in[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            last_idx <= IW'(MIN_LEN - 1);
            par_on   <= 1'b0;
            par_bit  <= 1'b0;
            two_q    <= 1'b0;
        end else if (load) begin
            data_q   <= data_in;
            last_idx <= last_n;
            par_on   <= par_sel[PAR_EN_BIT];
            par_bit  <= par_n;
            two_q    <= two_stop;
        end
    end
endmodule

// File: rtl/sfr_fsm.sv
module sfr_fsm #(
    parameter int DW = 9,
    localparam int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          start,
    input  logic [DW-1:0] data_q,
    input  logic [IW-1:0] last_idx,
    input  logic          par_on,
    input  logic          par_bit,
    input  logic          two_q,
    output logic          load,
    output logic          txd,
    output logic          busy,
    output logic          done
);
    import sfr_pkg::*;

    sfr_state_e    state;
    sfr_state_e    state_n;
    logic [IW-1:0] idx;
    logic [IW-1:0] idx_inc;
    logic          finish;

    assign idx_inc = idx + 1'b1;

    // the step that closes the final stop bit
    assign finish = step && ((state == ST_STOP2) || (state == ST_STOP1 && !two_q));

    assign load = start && ((state == ST_IDLE) || finish);
    assign busy = (state != ST_IDLE);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (start) state_n = ST_ARM;
            ST_ARM:   if (step) state_n = ST_START;
            ST_START: if (step) state_n = ST_DATA;
            ST_DATA: begin
                if (step && idx == last_idx) begin
                    state_n = par_on ? ST_PAR : ST_STOP1;
                end
            end
            ST_PAR:   if (step) state_n = ST_STOP1;
            ST_STOP1: begin
                if (step) begin
                    if (two_q)      state_n = ST_STOP2;
                    else if (start) state_n = ST_START;
                    else            state_n = ST_IDLE;
                end
            end
            ST_STOP2: begin
                if (step) state_n = start ? ST_START : ST_IDLE;
            end
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd  <= 1'b1;
            done <= 1'b0;
            idx  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: txd <= 1'b1;
                ST_ARM: begin
                    if (step) txd <= 1'b0;
                end
                ST_START: begin
                    if (step) begin
                        txd <= data_q[0];
                        idx <= '0;
                    end
                end
                ST_DATA: begin
                    if (step) begin
                        if (idx == last_idx) begin
                            txd <= par_on ? par_bit : 1'b1;
                        end else begin
                            idx <= idx_inc;
                            txd <= data_q[idx_inc];
                        end
                    end
                end
                ST_PAR: begin
                    if (step) txd <= 1'b1;
                end
                ST_STOP1, ST_STOP2: begin
                    if (finish) begin
                        done <= 1'b1;
                        txd  <= start ? 1'b0 : 1'b1;
                    end else if (step) begin
                        txd <= 1'b1;
                    end
                end
                default: txd <= 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/sfr_tx.sv
module sfr_tx #(
    parameter int DW      = 9,
    parameter int MIN_LEN = 5,
    parameter int LW      = 3,
    localparam int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] data_in,
    input  logic [LW-1:0] len_sel,
    input  logic [1:0]    par_sel,
    input  logic          two_stop,
    input  logic          sync_en,
    input  logic          clk_pol,
    input  logic          sclk_in,
    input  logic          tick,
    output logic          txd,
    output logic          busy,
    output logic          done
);
    logic          step;
    logic          load;
    logic [DW-1:0] data_q;
    logic [IW-1:0] last_idx;
    logic          par_on;
    logic          par_bit;
    logic          two_q;

    sfr_step_gen u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .sync_en (sync_en),
        .clk_pol (clk_pol),
        .sclk_in (sclk_in),
        .step    (step)
    );

    sfr_char_reg #(.DW(DW), .MIN_LEN(MIN_LEN), .LW(LW)) u_char (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .data_in  (data_in),
        .len_sel  (len_sel),
        .par_sel  (par_sel),
        .two_stop (two_stop),
        .data_q   (data_q),
        .last_idx (last_idx),
        .par_on   (par_on),
        .par_bit  (par_bit),
        .two_q    (two_q)
    );

    sfr_fsm #(.DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .start    (start),
        .data_q   (data_q),
        .last_idx (last_idx),
        .par_on   (par_on),
        .par_bit  (par_bit),
        .two_q    (two_q),
        .load     (load),
        .txd      (txd),
        .busy     (busy),
        .done     (done)
    );
endmodule

// File: rtl/sfr_tx_chk.sv
module sfr_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sync_en,
    input logic clk_pol,
    input logic sclk_in,
    input logic tick,
    input logic txd,
    input logic busy,
    input logic done
);
    logic sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_in;
    end

    // R7: idle line is high
    a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R7: line still high in the cycle busy rises
    a_r7_arm_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> txd);

    // R5: async changes only after a tick
    a_r5_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(txd) && !$past(sync_en)) |-> $past(tick));

    // R6: sync changes only after the selected serial clock edge
    a_r6_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(txd) && $past(sync_en) && !$past(clk_pol)) |-> ($past(sclk_in) && !$past(sclk_prev)));

    a_r6_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(txd) && $past(sync_en) && $past(clk_pol)) |-> (!$past(sclk_in) && $past(sclk_prev)));

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: busy only drops together with done
    a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9 and R10: done leaves either an idle high line or a fresh start bit
    a_r10_done_next: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((!busy && txd) || (busy && !txd)));
endmodule

bind sfr_tx sfr_tx_chk u_sfr_tx_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .sync_en (sync_en),
    .clk_pol (clk_pol),
    .sclk_in (sclk_in),
    .tick    (tick),
    .txd     (txd),
    .busy    (busy),
    .done    (done)
);

// File: tb/sfr_tx_test.sv
module sfr_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [8:0] data_in = '0;
    logic [2:0] len_sel = '0;
    logic [1:0] par_sel = '0;
    logic       two_stop = 1'b0;
    logic       sync_en = 1'b0;
    logic       clk_pol = 1'b0;
    logic       sclk_in = 1'b0;
    logic       tick = 1'b0;
    logic       txd;
    logic       busy;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int tdiv = 3;
    int sdiv = 2;
    int tcnt = 0;
    int scnt = 0;
    int n_done_seen = 0;
    int n_accept = 0;
    string cur_req = "R1";

    // model state
    bit m_busy = 1'b0;
    bit m_txd = 1'b1;
    bit m_done = 1'b0;
    bit m_prev = 1'b0;
    bit bitq[$];

    always #2.5 clk = ~clk;

    sfr_tx uut (
        .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
        .len_sel(len_sel), .par_sel(par_sel), .two_stop(two_stop),
        .sync_en(sync_en), .clk_pol(clk_pol), .sclk_in(sclk_in), .tick(tick),
        .txd(txd), .busy(busy), .done(done)
    );

    function automatic void build_frame();
        int  n;
        bit  p;
        n = (len_sel > 3'd4) ? 9 : int'(len_sel) + 5;
        p = 1'b0;
        bitq.delete();
        bitq.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            bitq.push_back(data_in[i]);
            p = p ^ data_in[i];
        end
        if (par_sel[1]) bitq.push_back(p ^ par_sel[0]);
        bitq.push_back(1'b1);
        if (two_stop) bitq.push_back(1'b1);
        n_accept++;
    endfunction

    always @(posedge clk) begin
        bit stp;
        if (!rst_n) begin
            m_busy = 1'b0; m_txd = 1'b1; m_done = 1'b0; m_prev = 1'b0;
            bitq.delete();
        end else begin
            if (sync_en) stp = clk_pol ? (!sclk_in && m_prev) : (sclk_in && !m_prev);
            else         stp = tick;
            m_prev = sclk_in;
            m_done = 1'b0;
            if (!m_busy) begin
                if (start) begin
                    build_frame();
                    m_busy = 1'b1;
                end
            end else if (stp) begin
                if (bitq.size() > 0) begin
                    m_txd = bitq.pop_front();
                end else begin
                    m_done = 1'b1;
                    if (start) begin
                        build_frame();
                        m_txd = bitq.pop_front();
                    end else begin
                        m_busy = 1'b0;
                        m_txd = 1'b1;
                    end
                end
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // stimulus pacing and per-clock comparison
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(cur_req, "txd", txd, m_txd);
            check("R7", "busy", busy, m_busy);
            check("R9", "done", done, m_done);
            if (done) n_done_seen++;
        end
        tcnt = (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
        tick <= (tcnt == 0);
        scnt = (scnt + 1 >= sdiv) ? 0 : scnt + 1;
        if (scnt == 0) sclk_in <= ~sclk_in;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wait_idle();
        int lim = 0;
        @(negedge clk);
        while (busy && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
    endtask

    task automatic send(input logic [8:0] d, input logic [2:0] l, input logic [1:0] p,
                        input logic s, input bit scramble);
        wait_idle();
        data_in = d; len_sel = l; par_sel = p; two_stop = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            data_in = ~d; len_sel = 3'd1; par_sel = ~p; two_stop = ~s;
            repeat (8) @(negedge clk);
            start = 1'b1;            // R8: strobe while busy
            @(negedge clk);
            start = 1'b0;
        end
        wait_idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R7", "reset txd", txd, 1);
        check("R7", "reset busy", busy, 0);
        check("R9", "reset done", done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R7", "idle busy", busy, 0);

        // R1 R2 R3 R4 R5: every format in async mode
        cur_req = "R2";
        for (int l = 0; l < 5; l++) begin
            for (int p = 0; p < 4; p++) begin
                if (p == 1) continue;
                for (int s = 0; s < 2; s++) begin
                    send(9'(37 * l + 11 * p + s + 5), 3'(l), 2'(p), 1'(s), 1'b0);
                end
            end
        end
        cur_req = "R3";
        send(9'h1A5, 3'd3, 2'b01, 1'b0, 1'b0);
        send(9'h0FF, 3'd4, 2'b11, 1'b1, 1'b0);
        cur_req = "R2";
        send(9'h155, 3'd6, 2'b10, 1'b0, 1'b0);

        // R8: inputs changed and extra strobe mid-frame
        cur_req = "R8";
        send(9'h0C3, 3'd3, 2'b10, 1'b1, 1'b1);
        send(9'h013, 3'd0, 2'b11, 1'b0, 1'b1);

        // R5: tick every cycle
        cur_req = "R5";
        tdiv = 1;
        send(9'h16B, 3'd4, 2'b10, 1'b1, 1'b0);
        tdiv = 3;

        // R6: synchronous mode, both polarities, tick keeps running
        cur_req = "R6";
        wait_idle();
        sync_en = 1'b1; clk_pol = 1'b0; sdiv = 2;
        send(9'h0A9, 3'd3, 2'b11, 1'b0, 1'b0);
        clk_pol = 1'b1;
        repeat (4) @(negedge clk);
        send(9'h1E1, 3'd4, 2'b10, 1'b1, 1'b0);
        sdiv = 3;
        send(9'h00D, 3'd0, 2'b00, 1'b1, 1'b0);
        sync_en = 1'b0; clk_pol = 1'b0;
        repeat (4) @(negedge clk);

        // R10: strobe held high chains frames with no idle gap
        begin
            int gaps = 0;
            int d0;
            int lim = 0;
            cur_req = "R10";
            wait_idle();
            d0 = n_done_seen;
            data_in = 9'h0B6; len_sel = 3'd0; par_sel = 2'b10; two_stop = 1'b0;
            start = 1'b1;
            @(negedge clk);
            while (n_done_seen < d0 + 3 && lim < 5000) begin
                if (!busy) gaps++;
                @(negedge clk);
                lim++;
            end
            start = 1'b0;
            check("R10", "idle cycles between chained frames", gaps, 0);
            wait_idle();
        end

        repeat (5) @(negedge clk);
        check("R9", "done pulses vs accepted frames", n_done_seen, n_accept);
        check("R7", "final idle txd", txd, 1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule